// File: doc/BRIEF.md
# Bidirectional FIFO Port Access Controller

This block is the control logic for one side of a two-way synchronous FIFO. On every rising edge of the port clock it samples the chip select, the read/write line, the transfer enable and a 3-bit address. It then decides what the port's 18-bit output register loads, which write strobe fires, and whether this side drives the shared data bus.

On a read, the address picks the source for the output register. The source is the head word of the FIFO (the read pointer advances), the bypass input register of the opposite port, or one of four 9-bit threshold offset registers, zero-extended to 18 bits. On a write, the bus word is captured and sent to the FIFO, to the bypass path or to an offset register.

The bus direction is clock-qualified. A sampled write turns the drivers off at that edge, even while output enable is still low. A write that arrives while the bus is being driven is rejected and flagged. The RAM, the pointer logic and the opposite port sit outside this block; they connect through plain strobe and data signals.

Top module: `sbf_port_ctrl`

## Requirements
- R1: A read cycle (cs_n=0, en_n=0, rw=1) with addr=000 raises fifo_rd during that cycle. At the edge it loads fifo_rdata into the output register (bus_out).
- R2: A read cycle with addr=001 raises byp_rd during that cycle and loads byp_data into bus_out at the edge. fifo_rd stays low.
- R3: A read cycle with addr=1XX loads the offset register selected by addr[1:0] into bus_out[8:0], with bus_out[17:9]=0.
- R4: A read cycle with addr=010 or 011 leaves bus_out unchanged and raises neither strobe.
- R5: With en_n=1, bus_out holds its value, no read strobe is raised and no write is performed, whatever the address.
- R6: With cs_n=1, the bus inputs are ignored, bus_oe is 0 and no transfer takes place.
- R7: bus_oe = !oe_n while cs_n=0 and the previous edge sampled cs_n=0 with rw=1. After an edge that sampled cs_n=0 with rw=0, bus_oe is 0 whatever oe_n is.
- R8: byp_mode rises at the edge that samples cs_n=0 with addr=001. It falls at the edge that samples addr=000 or cs_n=1. Any other address leaves it unchanged.
- R9: A legal write cycle (cs_n=0, en_n=0, rw=0, bus_oe=0) with addr=000 or 001 sets fifo_wr or byp_wr, respectively, for the one cycle after the edge. In that cycle wr_data carries the sampled bus_in.
- R10: A legal write cycle with addr=1XX stores bus_in[8:0] into offset register addr[1:0]. A later read returns the stored value.
- R11: A write cycle sampled while bus_oe=1 performs no write. seq_err is 1 for the following cycle.
- R12: While reset is applied, bus_out, bus_oe, byp_mode, fifo_wr, byp_wr and seq_err are 0 and all offset registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read, 0 = write |
| en_n | input | 1 | Transfer enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 3 | Source/target select |
| bus_in | input | 18 | Data from the bus pins |
| bus_out | output | 18 | Output register value to the bus pins |
| bus_oe | output | 1 | Bus driver enable |
| fifo_rd | output | 1 | FIFO read strobe (advance read pointer) |
| fifo_rdata | input | 18 | FIFO head word |
| byp_rd | output | 1 | Bypass word consumed strobe |
| byp_data | input | 18 | Opposite port's bypass input register |
| fifo_wr | output | 1 | FIFO write strobe |
| byp_wr | output | 1 | Bypass write strobe |
| wr_data | output | 18 | Captured write word |
| byp_mode | output | 1 | Bypass mode indication to the opposite port |
| seq_err | output | 1 | Illegal write-after-drive flag |

## Verification
The read strobes and bus_oe are combinational, so they are due in the same cycle as the inputs. The bench samples them 1 ns after driving the inputs on the falling edge. bus_out, byp_mode, wr_data, fifo_wr, byp_wr and seq_err each pass through one register, so they are due one rising edge later. The bench checks them at the next falling edge, before it drives new inputs. A reference model updates at each rising edge to give the expected values at exactly those points.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_FIFO = 2'd1,
    SRC_BYP  = 2'd2,
    SRC_OFS  = 2'd3
  } src_e;

  typedef struct packed {
    src_e rd_src;
    logic rd_cyc;
    logic wr_cyc;
    logic wr_fifo;
    logic wr_byp;
    logic wr_ofs;
  } cmd_t;
endpackage

// File: rtl/sbf_cmd_decode.sv
module sbf_cmd_decode
  import sbf_pkg::*;
(
  input  logic       cs_n,
  input  logic       rw,
  input  logic       en_n,
  input  logic [2:0] addr,
  output cmd_t       cmd
);
  logic active;

  always_comb begin
    active      = !cs_n && !en_n;
    cmd         = '0;
    cmd.rd_cyc  = active && rw;
    cmd.wr_cyc  = active && !rw;
    cmd.rd_src  = SRC_HOLD;
    if (cmd.rd_cyc) begin
      if (addr[2])             cmd.rd_src = SRC_OFS;
      else if (addr == 3'b000) cmd.rd_src = SRC_FIFO;
      else if (addr == 3'b001) cmd.rd_src = SRC_BYP;
    end
    cmd.wr_fifo = cmd.wr_cyc && (addr == 3'b000);
    cmd.wr_byp  = cmd.wr_cyc && (addr == 3'b001);
    cmd.wr_ofs  = cmd.wr_cyc && addr[2];
  end
endmodule

// File: rtl/sbf_offset_bank.sv
module sbf_offset_bank #(
  parameter int OFS_W = 9,
  parameter int OFS_N = 4,
  localparam int IDX_W = (OFS_N > 1) ? $clog2(OFS_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [OFS_W-1:0] wdata,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [OFS_W-1:0] rd_val
);
  logic [OFS_W-1:0] ofs_q [OFS_N];

  for (genvar g = 0; g < OFS_N; g++) begin : g_ofs
    logic             sel;
    logic [OFS_W-1:0] ofs_d;
    always_comb begin
      sel   = we && (wr_idx == IDX_W'(g));
      ofs_d = sel ? wdata : ofs_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ofs_q[g] <= '0;
      else        ofs_q[g] <= ofs_d;
    end
  end

  always_comb rd_val = ofs_q[rd_idx];
endmodule

// File: rtl/sbf_out_path.sv
module sbf_out_path
  import sbf_pkg::*;
#(
  parameter int DW    = 18,
  parameter int OFS_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  src_e             src,
  input  logic [DW-1:0]    fifo_rdata,
  input  logic [DW-1:0]    byp_data,
  input  logic [OFS_W-1:0] ofs_val,
  output logic [DW-1:0]    out_q
);
  logic [DW-1:0] out_d;

  always_comb begin
    unique case (src)
      SRC_FIFO: out_d = fifo_rdata;
      SRC_BYP:  out_d = byp_data;
      SRC_OFS:  out_d = DW'(ofs_val);
      default:  out_d = out_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end
endmodule

// File: rtl/sbf_port_ctrl.sv
module sbf_port_ctrl
  import sbf_pkg::*;
#(
  parameter int DW    = 18,
  parameter int OFS_W = 9,
  parameter int OFS_N = 4,
  localparam int IDX_W = (OFS_N > 1) ? $clog2(OFS_N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rw,
  input  logic          en_n,
  input  logic          oe_n,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          fifo_rd,
  input  logic [DW-1:0] fifo_rdata,
  output logic          byp_rd,
  input  logic [DW-1:0] byp_data,
  output logic          fifo_wr,
  output logic          byp_wr,
  output logic [DW-1:0] wr_data,
  output logic          byp_mode,
  output logic          seq_err
);
  // Reset: asserts asynchronously, releases on the second clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  cmd_t             cmd;
  logic [OFS_W-1:0] ofs_val;
  logic             dir_q, dir_d;
  logic             byp_q, byp_d;
  logic             err_d, fwr_d, bwr_d;
  logic [DW-1:0]    wd_q, wd_d;
  logic             wr_ok;

  sbf_cmd_decode u_dec (
    .cs_n (cs_n),
    .rw   (rw),
    .en_n (en_n),
    .addr (addr),
    .cmd  (cmd)
  );

  sbf_offset_bank #(.OFS_W(OFS_W), .OFS_N(OFS_N)) u_ofs (
    .clk    (clk),
    .rst_n  (rst_i),
    .we     (cmd.wr_ofs && wr_ok),
    .wr_idx (addr[IDX_W-1:0]),
    .wdata  (bus_in[OFS_W-1:0]),
    .rd_idx (addr[IDX_W-1:0]),
    .rd_val (ofs_val)
  );

  sbf_out_path #(.DW(DW), .OFS_W(OFS_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_i),
    .src        (cmd.rd_src),
    .fifo_rdata (fifo_rdata),
    .byp_data   (byp_data),
    .ofs_val    (ofs_val),
    .out_q      (bus_out)
  );

  always_comb begin
    bus_oe  = dir_q && !oe_n && !cs_n;
    wr_ok   = !bus_oe;
    fifo_rd = (cmd.rd_src == SRC_FIFO);
    byp_rd  = (cmd.rd_src == SRC_BYP);
    dir_d   = !cs_n && rw;
    if (cs_n)                 byp_d = 1'b0;
    else if (addr == 3'b001)  byp_d = 1'b1;
    else if (addr == 3'b000)  byp_d = 1'b0;
    else                      byp_d = byp_q;
    err_d   = cmd.wr_cyc && bus_oe;
    fwr_d   = cmd.wr_fifo && wr_ok;
    bwr_d   = cmd.wr_byp && wr_ok;
    wd_d    = (fwr_d || bwr_d) ? bus_in : wd_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      dir_q   <= 1'b0;
      byp_q   <= 1'b0;
      seq_err <= 1'b0;
      fifo_wr <= 1'b0;
      byp_wr  <= 1'b0;
      wd_q    <= '0;
    end else begin
      dir_q   <= dir_d;
      byp_q   <= byp_d;
      seq_err <= err_d;
      fifo_wr <= fwr_d;
      byp_wr  <= bwr_d;
      wd_q    <= wd_d;
    end
  end

  assign byp_mode = byp_q;
  assign wr_data  = wd_q;

  // Checks on the output register, the bus direction and the write path.
  a_r1_fifo_load: assert property (@(posedge clk) disable iff (!rst_i)
    fifo_rd |=> bus_out == $past(fifo_rdata));
  a_r2_byp_load: assert property (@(posedge clk) disable iff (!rst_i)
    byp_rd |=> bus_out == $past(byp_data));
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_i)
    !(fifo_rd && byp_rd));
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_i)
    (en_n || cs_n) |=> $stable(bus_out));
  a_r6_no_bypass_deselected: assert property (@(posedge clk) disable iff (!rst_i)
    cs_n |=> !byp_mode);
  a_r7_write_releases_bus: assert property (@(posedge clk) disable iff (!rst_i)
    (!cs_n && !rw) |=> !bus_oe);
  a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_i)
    !(fifo_wr && byp_wr));
  a_r11_rejected_write: assert property (@(posedge clk) disable iff (!rst_i)
    (!cs_n && !en_n && !rw && bus_oe) |=> (seq_err && !fifo_wr && !byp_wr));
endmodule

// File: tb/tb_sbf_port_ctrl.sv
module tb_sbf_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, rw, en_n, oe_n;
  logic [2:0]  addr;
  logic [17:0] bus_in, fifo_rdata, byp_data;
  logic [17:0] bus_out, wr_data;
  logic        bus_oe, fifo_rd, byp_rd, fifo_wr, byp_wr, byp_mode, seq_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [17:0] m_out, m_wd;
  logic [8:0]  m_ofs [4];
  logic        m_dir, m_byp, m_fwr, m_bwr, m_err;

  always #4 clk = ~clk;

  sbf_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rw(rw), .en_n(en_n), .oe_n(oe_n),
    .addr(addr), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .fifo_rd(fifo_rd), .fifo_rdata(fifo_rdata), .byp_rd(byp_rd),
    .byp_data(byp_data), .fifo_wr(fifo_wr), .byp_wr(byp_wr),
    .wr_data(wr_data), .byp_mode(byp_mode), .seq_err(seq_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string out_tag(input logic c, input logic e, input logic r,
                                    input logic [2:0] a);
    if (c)             return "R6 bus_out";
    if (e)             return "R5 bus_out";
    if (!r)            return "R9 bus_out";
    if (a == 3'b000)   return "R1 bus_out";
    if (a == 3'b001)   return "R2 bus_out";
    if (a[2])          return "R3 bus_out";
    return "R4 bus_out";
  endfunction

  function automatic logic exp_bus_oe(input logic d, input logic c, input logic o);
    return d && !o && !c;
  endfunction

  // Drive at the falling edge, check the same-cycle results, advance one edge,
  // then check the registered results.
  task automatic step(input logic c, input logic r, input logic e, input logic o,
                      input logic [2:0] a, input logic [17:0] b);
    logic eoe, rd, wr, legal;
    cs_n = c; rw = r; en_n = e; oe_n = o; addr = a; bus_in = b;
    fifo_rdata = 18'($urandom); byp_data = 18'($urandom);
    #1;
    eoe = exp_bus_oe(m_dir, c, o);
    rd  = !c && !e && r;
    wr  = !c && !e && !r;
    chk("R7 bus_oe", 32'(bus_oe), 32'(eoe));
    chk("R1 fifo_rd", 32'(fifo_rd), 32'(rd && a == 3'b000));
    chk("R2 byp_rd", 32'(byp_rd), 32'(rd && a == 3'b001));
    @(posedge clk);
    if (rd) begin
      if (a == 3'b000)      m_out = fifo_rdata;
      else if (a == 3'b001) m_out = byp_data;
      else if (a[2])        m_out = {9'b0, m_ofs[a[1:0]]};
    end
    legal = wr && !eoe;
    m_err = wr && eoe;
    m_fwr = legal && a == 3'b000;
    m_bwr = legal && a == 3'b001;
    if (m_fwr || m_bwr) m_wd = b;
    if (legal && a[2]) m_ofs[a[1:0]] = b[8:0];
    m_dir = !c && r;
    if (c)                m_byp = 1'b0;
    else if (a == 3'b001) m_byp = 1'b1;
    else if (a == 3'b000) m_byp = 1'b0;
    @(negedge clk);
    chk(out_tag(c, e, r, a), 32'(bus_out), 32'(m_out));
    chk("R8 byp_mode", 32'(byp_mode), 32'(m_byp));
    chk("R9 fifo_wr", 32'(fifo_wr), 32'(m_fwr));
    chk("R9 byp_wr", 32'(byp_wr), 32'(m_bwr));
    if (m_fwr || m_bwr) chk("R9 wr_data", 32'(wr_data), 32'(m_wd));
    chk("R11 seq_err", 32'(seq_err), 32'(m_err));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_out = '0; m_wd = '0; m_dir = 0; m_byp = 0; m_fwr = 0; m_bwr = 0; m_err = 0;
    for (int i = 0; i < 4; i++) m_ofs[i] = '0;
    rst_n = 1'b0; cs_n = 1; rw = 1; en_n = 1; oe_n = 1; addr = 0;
    bus_in = 0; fifo_rdata = 0; byp_data = 0;
    repeat (3) @(negedge clk);
    // R12: values held under reset, even with an active read requested
    cs_n = 0; en_n = 0; oe_n = 0; addr = 3'b001;
    @(posedge clk); @(negedge clk);
    chk("R12 bus_out", 32'(bus_out), 0);
    chk("R12 bus_oe", 32'(bus_oe), 0);
    chk("R12 byp_mode", 32'(byp_mode), 0);
    chk("R12 fifo_wr", 32'(fifo_wr), 0);
    chk("R12 seq_err", 32'(seq_err), 0);
    cs_n = 1; en_n = 1; oe_n = 1;
    rst_n = 1'b1;
    repeat (3) step(1, 1, 1, 1, 3'b000, 18'h0);
    // R12: offset registers read back as 0 after reset
    step(0, 1, 0, 1, 3'b110, 18'h0);
    chk("R12 offset", 32'(bus_out), 0);
    // R10: write each offset register, read back
    for (int k = 0; k < 4; k++) step(0, 0, 0, 1, {1'b1, 2'(k)}, 18'h3FE00 | 18'(k * 37 + 5));
    for (int k = 0; k < 4; k++) begin
      step(0, 1, 0, 1, {1'b1, 2'(k)}, 18'h0);
      chk("R10 offset readback", 32'(bus_out), 32'(k * 37 + 5));
    end
    // R1, R2, R4 directed reads
    step(0, 1, 0, 1, 3'b000, 18'h0);
    step(0, 1, 0, 1, 3'b001, 18'h0);
    step(0, 1, 0, 1, 3'b010, 18'h0);
    step(0, 1, 0, 1, 3'b011, 18'h0);
    // R8: bypass mode held by other addresses, cleared by 000
    step(0, 1, 1, 1, 3'b001, 18'h0);
    step(0, 1, 1, 1, 3'b101, 18'h0);
    chk("R8 held", 32'(byp_mode), 1);
    step(0, 1, 1, 1, 3'b000, 18'h0);
    chk("R8 cleared", 32'(byp_mode), 0);
    // R11: a driven read cycle, then a write while still driven
    step(0, 1, 0, 0, 3'b000, 18'h0);
    step(0, 0, 0, 0, 3'b000, 18'h1234);
    chk("R11 rejected", 32'(seq_err), 1);
    // R7: after the write edge the bus stays released with oe_n low
    step(0, 0, 1, 0, 3'b000, 18'h0);
    // R9: legal writes to FIFO and bypass
    step(0, 0, 0, 1, 3'b000, 18'h2AAAA);
    step(0, 0, 0, 1, 3'b001, 18'h15555);
    // R6: deselected writes ignored
    step(1, 0, 0, 0, 3'b100, 18'h1FF);
    step(0, 1, 0, 1, 3'b100, 18'h0);
    chk("R6 offset unchanged", 32'(bus_out), 5);
    // constrained random
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 8) == 0, $urandom % 2, ($urandom % 4) == 0,
           ($urandom % 3) == 0, 3'($urandom), 18'($urandom));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule